// File: doc/BRIEF.md
# Real-Time Trace Address Emitter

This block watches the instruction retire stream and sends the target address of each traceable change of flow out over one shared 8-bit status/data port. A change of flow is traceable when its target is computed at run time (the indirect class). Absolute and PC-relative branches can be rebuilt from the program image, so they are not traced. The debug command logic can also raise a sync request, which forces the current instruction address out whatever the class.

Each traced address is written into a small queue. The block then sends it as a packet: first a length marker, then the 32-bit address one byte per cycle, least significant byte first. When ASID display was enabled at the moment of the request, a final byte carries the 8-bit address space identifier, so the host sees the full 40-bit virtual address. An idle code fills the bus between packets. If a request arrives while the queue is full, the request is dropped and a sticky overflow flag is set. Dropping trace-enable stops the stream at once and clears the queue.

The packet engine has four states:
- `S_IDLE` drives the idle code.
- `S_MARK` drives the marker.
- `S_ADDR` steps a byte index from 0 to 3.
- `S_ASID` drives the identifier byte.

The transitions are:
- `S_IDLE`→`S_MARK` when the queue is not empty.
- `S_MARK`→`S_ADDR` always.
- `S_ADDR`→`S_ADDR` while the index is below 3.
- At index 3, `S_ADDR`→`S_ASID` for a tagged entry. For an untagged entry it goes to `S_MARK` if the queue is not empty, otherwise to `S_IDLE`.
- `S_ASID`→`S_MARK` or `S_IDLE`, chosen the same way.
- Any state →`S_IDLE` when trace-enable is low.

Top module: `trace_addr_emitter`

## Requirements
- R1: After reset `pst_bus` carries the idle code 0x00 and `trace_ovf` is 0.
- R2: With `trace_en` high, a request is taken when `retire_vld` is high with `retire_cls` = 3 (indirect). The classes 0 (sequential), 1 (absolute) and 2 (PC-relative) produce no output, and class 3 produces none while `retire_vld` is low.
- R3: A packet is the marker 0xA4 (untagged) or 0xA5 (tagged), then address bits [7:0], [15:8], [23:16], [31:24] on consecutive cycles. The marker appears in the second cycle after the clock edge that sampled the request.
- R4: A packet carries a fifth byte holding the `cur_asid` value sampled with the request exactly when `asid_show_en` was high at that edge. Later changes to `asid_show_en` do not alter queued entries.
- R5: `sync_req` high with `trace_en` high enqueues `target_addr` and `cur_asid` for any class. When it coincides with an indirect retire, exactly one packet is produced.
- R6: When another entry is queued, its marker follows the last byte of the previous packet on the very next cycle, with no idle cycle between.
- R7: The queue holds `DEPTH` entries (default 4). A request sampled while the queue is full is dropped, even if an entry leaves on the same edge. The drop sets `trace_ovf`, which stays 1 until reset.
- R8: An edge that samples `trace_en` low returns `pst_bus` to 0x00 on the following cycle, discards queued entries and accepts no request.
- R9: The idle code 0x00 is driven on every cycle in which no packet byte is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_cls | input | 2 | Class of the retiring instruction: 0 seq, 1 absolute, 2 PC-relative, 3 indirect |
| target_addr | input | 32 | Target or current instruction address |
| cur_asid | input | 8 | Current address space identifier |
| trace_en | input | 1 | Real-time trace enable |
| asid_show_en | input | 1 | Append the identifier byte to new packets |
| sync_req | input | 1 | Forced address emission from the debug command path |
| pst_bus | output | 8 | Combined status/data output byte |
| trace_ovf | output | 1 | Sticky queue-overflow flag |

## Verification
Two events can fall on the same edge. A sync request can coincide with an indirect retire. A new request can also arrive at a full queue on the very edge where the packet engine removes an entry. The bench drives both on purpose: a sync pulse together with a class-3 retire, and a run of back-to-back requests that keeps the queue full while packets drain. A behavioural queue model predicts each output byte and the overflow flag, and the bench compares them every cycle. It checks that the coincident pair yields one packet and that the request arriving at full is lost with the flag raised, even though a slot opens on that edge.

// File: rtl/trace_emit_pkg.sv
package trace_emit_pkg;
    localparam int ADDR_W = 32;
    localparam int ASID_W = 8;
    localparam int BUS_W  = 8;

    localparam logic [1:0]       CLS_INDIRECT = 2'd3;
    localparam logic [BUS_W-1:0] CODE_IDLE    = 8'h00;
    localparam logic [BUS_W-1:0] CODE_MARK4   = 8'hA4;
    localparam logic [BUS_W-1:0] CODE_MARK5   = 8'hA5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MARK,
        S_ADDR,
        S_ASID
    } emit_state_e;

    typedef struct packed {
        logic              tag;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] addr;
    } trace_ent_t;
endpackage

// File: rtl/trace_req_fifo.sv
module trace_req_fifo
    import trace_emit_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  trace_ent_t       din,
    input  logic             pop,
    output trace_ent_t       dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    trace_ent_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);
endmodule

// File: rtl/trace_pkt_fsm.sv
module trace_pkt_fsm
    import trace_emit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_en,
    input  logic             q_empty,
    input  trace_ent_t       q_head,
    output logic             q_pop,
    output logic [BUS_W-1:0] pst_bus
);
    emit_state_e state, state_nx;
    logic [1:0]  byte_idx, byte_idx_nx;
    trace_ent_t  cur;
    logic        pkt_last;

    always_comb begin
        pkt_last = (state == S_ASID) ||
                   (state == S_ADDR && byte_idx == 2'd3 && !cur.tag);
        q_pop    = trace_en && !q_empty && (state == S_IDLE || pkt_last);
    end

    always_comb begin
        state_nx    = state;
        byte_idx_nx = byte_idx;
        if (!trace_en) begin
            state_nx    = S_IDLE;
            byte_idx_nx = '0;
        end else begin
            unique case (state)
                S_IDLE: if (q_pop) state_nx = S_MARK;
                S_MARK: begin
                    state_nx    = S_ADDR;
                    byte_idx_nx = '0;
                end
                S_ADDR: begin
                    if (byte_idx != 2'd3) byte_idx_nx = byte_idx + 1'b1;
                    else if (cur.tag)     state_nx = S_ASID;
                    else                  state_nx = q_pop ? S_MARK : S_IDLE;
                end
                S_ASID: state_nx = q_pop ? S_MARK : S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            byte_idx <= '0;
            cur      <= '0;
        end else begin
            state    <= state_nx;
            byte_idx <= byte_idx_nx;
            if (q_pop) cur <= q_head;
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE: pst_bus = CODE_IDLE;
            S_MARK: pst_bus = cur.tag ? CODE_MARK5 : CODE_MARK4;
            S_ADDR: pst_bus = cur.addr[{byte_idx, 3'b000} +: 8];
            S_ASID: pst_bus = cur.asid;
        endcase
    end

    assert_mark_to_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MARK && trace_en) |=> (state == S_ADDR && byte_idx == 2'd0));
    assert_tag_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && byte_idx == 2'd3 && cur.tag && trace_en) |=> (state == S_ASID));
    assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_last && trace_en && !q_empty) |=> (state == S_MARK));
endmodule

// File: rtl/trace_addr_emitter.sv
module trace_addr_emitter
    import trace_emit_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        retire_vld,
    input  logic [1:0]  retire_cls,
    input  logic [31:0] target_addr,
    input  logic [7:0]  cur_asid,
    input  logic        trace_en,
    input  logic        asid_show_en,
    input  logic        sync_req,
    output logic [7:0]  pst_bus,
    output logic        trace_ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             req, push, pop, q_empty, q_full;
    logic [CNT_W-1:0] q_cnt;
    trace_ent_t       new_ent, head_ent;

    always_comb begin
        req          = trace_en && ((retire_vld && retire_cls == CLS_INDIRECT) || sync_req);
        push         = req && !q_full;
        new_ent.tag  = asid_show_en;
        new_ent.asid = cur_asid;
        new_ent.addr = target_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             trace_ovf <= 1'b0;
        else if (req && q_full) trace_ovf <= 1'b1;
    end

    trace_req_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!trace_en),
        .push  (push),
        .din   (new_ent),
        .pop   (pop),
        .dout  (head_ent),
        .empty (q_empty),
        .full  (q_full),
        .count (q_cnt)
    );

    trace_pkt_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trace_en (trace_en),
        .q_empty  (q_empty),
        .q_head   (head_ent),
        .q_pop    (pop),
        .pst_bus  (pst_bus)
    );

    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> (pst_bus == CODE_IDLE && q_cnt == '0));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trace_ovf |=> trace_ovf);
    assert_no_gain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !sync_req && !(retire_vld && retire_cls == CLS_INDIRECT))
        |=> (q_cnt <= $past(q_cnt)));
    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && q_full) |=> trace_ovf);
endmodule

// File: tb/test_trace_addr_emitter.sv
module test_trace_addr_emitter;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_vld = 1'b0;
    logic [1:0]  retire_cls = 2'd0;
    logic [31:0] target_addr = '0;
    logic [7:0]  cur_asid = '0;
    logic        trace_en = 1'b0;
    logic        asid_show_en = 1'b0;
    logic        sync_req = 1'b0;
    logic [7:0]  pst_bus;
    logic        trace_ovf;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    trace_addr_emitter #(.DEPTH(DEPTH)) i_trace_addr_emitter (
        .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_cls(retire_cls),
        .target_addr(target_addr), .cur_asid(cur_asid), .trace_en(trace_en),
        .asid_show_en(asid_show_en), .sync_req(sync_req),
        .pst_bus(pst_bus), .trace_ovf(trace_ovf)
    );

    // behavioural reference: queue of pending requests and a byte stream
    logic [40:0] pend[$];
    logic [7:0]  obuf[$];
    bit          m_ovf;
    bit          m_full, m_req;
    logic [40:0] e;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete(); obuf.delete(); m_ovf = 0;
        end else if (!trace_en) begin
            pend.delete(); obuf.delete();
        end else begin
            m_full = (pend.size() >= DEPTH);
            m_req  = (retire_vld && retire_cls == 2'd3) || sync_req;
            if (obuf.size() > 0) void'(obuf.pop_front());
            if (obuf.size() == 0 && pend.size() > 0) begin
                e = pend.pop_front();
                obuf.push_back(e[40] ? 8'hA5 : 8'hA4);
                for (int i = 0; i < 4; i++) obuf.push_back(e[8*i +: 8]);
                if (e[40]) obuf.push_back(e[39:32]);
            end
            if (m_req) begin
                if (m_full) m_ovf = 1;
                else pend.push_back({asid_show_en, cur_asid, target_addr});
            end
        end
    end

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", phase, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(pst_bus, (obuf.size() > 0) ? obuf[0] : 8'h00, "pst_bus");
            check({7'd0, trace_ovf}, {7'd0, m_ovf}, "trace_ovf");
        end
    end

    task automatic req(input logic v, input logic [1:0] c, input logic [31:0] a,
                       input logic [7:0] s, input logic sy);
        @(negedge clk);
        retire_vld = v; retire_cls = c; target_addr = a; cur_asid = s; sync_req = sy;
        @(negedge clk);
        retire_vld = 0; retire_cls = 0; sync_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pst_bus, 8'h00, "reset pst_bus");
        check({7'd0, trace_ovf}, 8'h00, "reset ovf");
        rst_n = 1;
        trace_en = 1;
        idle(2);
        phase = "R3"; req(1, 2'd3, 32'h1234_5678, 8'h9A, 0); idle(8);
        phase = "R4"; asid_show_en = 1; req(1, 2'd3, 32'hCAFE_F00D, 8'h5C, 0);
        asid_show_en = 0; idle(9);
        phase = "R2";
        req(1, 2'd0, 32'h1111_1111, 8'h01, 0);
        req(1, 2'd1, 32'h2222_2222, 8'h02, 0);
        req(1, 2'd2, 32'h3333_3333, 8'h03, 0);
        req(0, 2'd3, 32'h4444_4444, 8'h04, 0);
        idle(4);
        phase = "R5"; req(1, 2'd0, 32'hDEAD_BEEF, 8'h77, 1); idle(8);
        req(1, 2'd3, 32'hABCD_0123, 8'h66, 1); idle(10);
        phase = "R6";
        asid_show_en = 1; req(1, 2'd3, 32'h0000_00FF, 8'hE1, 0);
        asid_show_en = 0; req(1, 2'd3, 32'hFF00_0000, 8'hE2, 0);
        idle(16);
        phase = "R7";
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            retire_vld = 1; retire_cls = 2'd3; target_addr = 32'h1000 + k; cur_asid = 8'(k);
            asid_show_en = k[0];
        end
        @(negedge clk); retire_vld = 0; asid_show_en = 0;
        idle(20);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            sync_req = 1; target_addr = 32'h8000_0000 + k;
        end
        @(negedge clk); sync_req = 0;
        idle(3);
        phase = "R8"; trace_en = 0;
        req(1, 2'd3, 32'h5555_AAAA, 8'h12, 1);
        idle(3); trace_en = 1; idle(6);
        phase = "R9"; idle(20);
        // R7 flag held after everything
        check({7'd0, trace_ovf}, 8'h01, "sticky ovf");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog actual=hung expected=done", phase);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule